// File: doc/BRIEF.md
# Software-Bracketed Cycle Timer

This block times a stretch of software in units of the system clock. The processor writes a 2-bit marker into a register whose output drives this block. It writes the start code just before the code under test and the done code just after it. The block counts clock cycles between the two markers and saturates rather than wrapping. It holds the finished count in binary. It then converts that count into packed BCD digits for a display. A valid flag tells the display side when the digits match the held count.

The count width and the digit count are parameters. The defaults are a 33-bit count and 10 decimal digits, which covers the full range of the count. With a 50 MHz clock, the defaults measure intervals up to roughly 170 seconds. The marker path is decoded on transitions, so writing the same code again has no effect. Only a fresh move into the start code or into the done code is an event.

Top module: `swcyc_timer`

## Requirements
- R1: After reset, the binary result, all BCD digits and the valid flag are zero.
- R2: A clock where the marker equals 01 and the previously sampled marker did not equal 01 starts a measurement with the counter at zero. This also applies while a measurement is already running, in which case the measurement restarts.
- R3: A clock where the marker equals 10, the previously sampled marker did not equal 10, and a measurement is running ends the measurement. The result becomes N, the number of clock edges after the starting edge up to and including this ending edge. The result appears on the binary output after that edge.
- R4: Markers 00 and 11, a repeated 01 or 10, and a move into 10 while no measurement runs change neither the result, the digits nor the valid flag.
- R5: The count saturates at 2^CNT_W-1 and never wraps.
- R6: The result stays unchanged until the next measurement ends. Starting a new measurement does not disturb the result, the digits or the valid flag.
- R7: The valid flag drops on the edge that ends a measurement. It rises exactly CNT_W clock edges later.
- R8: While valid is high, the BCD output holds the decimal value of the result. Digit k sits in bits [4k+3:4k], and digit 0 is the least significant. Each digit lies in the range 0 to 9. The digits only change on the edge where valid rises.
- R9: If a measurement ends while a conversion is still in progress, the conversion restarts on the new result. Valid then rises CNT_W edges after that later ending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flag_i | input | 2 | Marker written by software: 01 start, 10 done |
| count_o | output | CNT_W | Last completed cycle count, binary |
| bcd_o | output | 4*DIGITS | Last converted count as packed BCD |
| valid_o | output | 1 | BCD output matches count_o |

## Verification
The assertions take for granted that the marker is synchronous to the system clock and is stable around each rising edge, since a register inside the same clock domain produces it. They also assume that reset is applied once before any marker activity. The bench changes the marker only on falling edges. The changes follow a sequence that visits every code and repeats codes. The sequence also ends a measurement while idle, restarts a measurement mid-run, and ends measurements back to back inside a conversion window.

// File: rtl/swcyc_pkg.sv
package swcyc_pkg;
  localparam logic [1:0] MARK_IDLE  = 2'b00;
  localparam logic [1:0] MARK_START = 2'b01;
  localparam logic [1:0] MARK_DONE  = 2'b10;

  typedef enum logic {CV_IDLE = 1'b0, CV_RUN = 1'b1} conv_st_e;
endpackage

// File: rtl/swcyc_mark_decode.sv
module swcyc_mark_decode
  import swcyc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] flag_i,
  output logic       start_o,
  output logic       stop_o
);
  logic [1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= MARK_IDLE;
    else         prev_q <= flag_i;
  end

  // Events are entries into a code, so rewriting a code is harmless.
  assign start_o = (flag_i == MARK_START) && (prev_q != MARK_START);
  assign stop_o  = (flag_i == MARK_DONE)  && (prev_q != MARK_DONE);
endmodule

// File: rtl/swcyc_counter.sv
module swcyc_counter #(
  parameter int CNT_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             running_o,
  output logic [CNT_W-1:0] live_o,
  output logic             cap_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;

  assign cap_o     = stop_i && run_q;
  assign cap_val_o = sat_inc(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      res_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (cap_o) begin
      run_q <= 1'b0;
      res_q <= cap_val_o;
    end else if (run_q) begin
      cnt_q <= sat_inc(cnt_q);
    end
  end

  assign running_o = run_q;
  assign live_o    = cnt_q;
  assign result_o  = res_q;
endmodule

// File: rtl/swcyc_bcd_conv.sv
module swcyc_bcd_conv
  import swcyc_pkg::*;
#(
  parameter int CNT_W  = 33,
  parameter int DIGITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    value_i,
  output logic [DIGITS*4-1:0] bcd_o,
  output logic                valid_o
);
  localparam int BCD_W = DIGITS * 4;
  localparam int IT_W  = $clog2(CNT_W + 1);
  localparam logic [IT_W-1:0] LAST_IT = IT_W'(CNT_W - 1);

  // One shift-and-add-3 step: correct every digit, then shift in one bit.
  function automatic logic [BCD_W-1:0] dabble(input logic [BCD_W-1:0] b,
                                               input logic in_bit);
    logic [BCD_W-1:0] t;
    t = b;
    for (int d = 0; d < DIGITS; d++) begin
      if (t[d*4 +: 4] >= 4'd5) t[d*4 +: 4] = t[d*4 +: 4] + 4'd3;
    end
    return {t[BCD_W-2:0], in_bit};
  endfunction

  conv_st_e         st_q;
  logic [IT_W-1:0]  it_q;
  logic [CNT_W-1:0] sh_q;
  logic [BCD_W-1:0] acc_q;
  logic [BCD_W-1:0] out_q;
  logic             vld_q;
  logic [BCD_W-1:0] acc_nxt;

  assign acc_nxt = dabble(acc_q, sh_q[CNT_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CV_IDLE;
      it_q  <= '0;
      sh_q  <= '0;
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (load_i) begin
      st_q  <= CV_RUN;
      it_q  <= '0;
      sh_q  <= value_i;
      acc_q <= '0;
      vld_q <= 1'b0;
    end else if (st_q == CV_RUN) begin
      acc_q <= acc_nxt;
      sh_q  <= sh_q << 1;
      it_q  <= it_q + 1'b1;
      if (it_q == LAST_IT) begin
        out_q <= acc_nxt;
        vld_q <= 1'b1;
        st_q  <= CV_IDLE;
      end
    end
  end

  assign bcd_o   = out_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/swcyc_timer.sv
module swcyc_timer #(
  parameter int CNT_W  = 33,
  parameter int DIGITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          flag_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [DIGITS*4-1:0] bcd_o,
  output logic                valid_o
);
  // Internal events, named for the checker.
  logic             start_evt;
  logic             stop_evt;
  logic             cap_evt;
  logic             running;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] cap_val;

  swcyc_mark_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flag_i  (flag_i),
    .start_o (start_evt),
    .stop_o  (stop_evt)
  );

  swcyc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_evt),
    .stop_i    (stop_evt),
    .running_o (running),
    .live_o    (live_cnt),
    .cap_o     (cap_evt),
    .cap_val_o (cap_val),
    .result_o  (count_o)
  );

  swcyc_bcd_conv #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_bcd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cap_evt),
    .value_i (cap_val),
    .bcd_o   (bcd_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/swcyc_timer_chk.sv
module swcyc_timer_chk #(
  parameter int CNT_W  = 33,
  parameter int DIGITS = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                cap_evt,
  input logic                running,
  input logic [CNT_W-1:0]    live_cnt,
  input logic [CNT_W-1:0]    count_o,
  input logic [DIGITS*4-1:0] bcd_o,
  input logic                valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (running && live_cnt == '0));

  a_r3_stop_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && live_cnt != CNT_MAX) |=> (!running && count_o == $past(live_cnt) + 1'b1));

  a_r4_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_evt && !running) |=> !running);

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start_evt && !stop_evt && live_cnt == CNT_MAX) |=> live_cnt == CNT_MAX);

  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt |=> $stable(count_o));

  a_r7_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> !valid_o);

  a_r8_digits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cap_evt) |=> (valid_o && $stable(bcd_o)));

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    a_r8_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (bcd_o[d*4 +: 4] <= 4'd9));
  end
endmodule

bind swcyc_timer swcyc_timer_chk #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .cap_evt   (cap_evt),
  .running   (running),
  .live_cnt  (live_cnt),
  .count_o   (count_o),
  .bcd_o     (bcd_o),
  .valid_o   (valid_o)
);

// File: tb/swcyc_timer_bench.sv
module swcyc_timer_bench;
  localparam int CNT_W  = 10;
  localparam int DIGITS = 4;
  localparam longint MAXV = (64'sd1 <<< CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          flag = 2'b00;
  logic [CNT_W-1:0]    count;
  logic [DIGITS*4-1:0] bcd;
  logic                valid;

  always #10 clk = ~clk;

  swcyc_timer #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_swcyc_timer (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag),
    .count_o(count), .bcd_o(bcd), .valid_o(valid)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // Behavioural reference state.
  int     m_prev = 0;
  bit     m_run = 0;
  longint m_cnt = 0, m_res = 0, m_conv = 0, m_shown = 0;
  bit     m_valid = 0;
  int     m_cd = 0;

  function automatic longint to_bcd(input longint v);
    longint r = 0;
    longint x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r = r + ((x % 10) << (4 * i));
      x = x / 10;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_run = 0; m_cnt = 0; m_res = 0; m_conv = 0;
      m_shown = 0; m_valid = 0; m_cd = 0;
    end else begin
      int f;
      f = int'(flag);
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin m_valid = 1; m_shown = m_conv; end
      end
      if (f == 1 && m_prev != 1) begin
        m_run = 1; m_cnt = 0;
      end else if (f == 2 && m_prev != 2 && m_run) begin
        m_res = (m_cnt + 1 > MAXV) ? MAXV : m_cnt + 1;
        m_run = 0; m_valid = 0; m_cd = CNT_W; m_conv = m_res;
      end else if (m_run) begin
        m_cnt = (m_cnt + 1 > MAXV) ? MAXV : m_cnt + 1;
      end
      m_prev = f;
    end
  end

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("count", longint'(count), m_res);
      check("valid", longint'(valid), longint'(m_valid));
      check("bcd", longint'(bcd), to_bcd(m_shown));
    end
  end

  task automatic hold(input logic [1:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      flag = code;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports.
    check("R1 count reset", longint'(count), 0);
    check("R1 bcd reset", longint'(bcd), 0);
    check("R1 valid reset", longint'(valid), 0);
    rst_n = 1'b1;
    // R4: idle codes and a done code with nothing running.
    tag = "R4";
    hold(2'b00, 3); hold(2'b11, 3); hold(2'b10, 4); hold(2'b00, 2);
    // R2 R3: basic bracket, with 11 and a repeated 01 in the middle.
    tag = "R3";
    hold(2'b01, 5); hold(2'b11, 4); hold(2'b10, 1); hold(2'b10, 3);
    // R7 R8: wait out the conversion.
    tag = "R8";
    hold(2'b00, CNT_W + 4);
    // R6: a new start leaves the held result and digits alone.
    tag = "R6";
    hold(2'b01, 8); hold(2'b00, 3);
    // R2: restart mid-run by re-entering 01.
    tag = "R2";
    hold(2'b01, 6); hold(2'b10, 1); hold(2'b00, CNT_W + 3);
    // R9: two completions inside one conversion window.
    tag = "R9";
    hold(2'b01, 7); hold(2'b10, 2); hold(2'b01, 3); hold(2'b10, 1);
    hold(2'b00, CNT_W + 3);
    // R7: plain completion, then a long wait.
    tag = "R7";
    hold(2'b01, 123); hold(2'b10, CNT_W + 5);
    // R5: run past the count limit.
    tag = "R5";
    hold(2'b01, 1100); hold(2'b10, CNT_W + 5);
    tag = "R5";
    check("R5 saturated count", longint'(count), MAXV);
    check("R5 saturated digits", longint'(bcd), to_bcd(MAXV));
    finish_run();
  end
endmodule